// File: doc/BRIEF.md
# Serial Flash Parameter Table Decoder

This block takes the 32-bit little-endian words that a flash reader fetches from a serial flash's discoverable-parameter space and turns them into a register set that the rest of the flash controller can use. A start pulse arms the block. The words then arrive one per accepted `word_valid` cycle in this order: the two header words, the two words of the first parameter header, and the basic parameter table words.

The header and parameter header are checked as they arrive. The upstream reader takes the table pointer and the table length from the outputs and fetches the table itself. Each table word is decoded in the cycle it is accepted. Decoding covers:
- capacity and page size;
- up to four erase types with their erase times and timeouts;
- mass-erase and page-program times;
- the write-enable opcode and the quad fast-read opcode, mode clocks and dummy cycles;
- the quad-enable code, execute-in-place support and its entry method;
- the status-polling style.

An unsupported header or configuration stops the parse at once, with a distinct error code. Completion, good or bad, is marked by a one-cycle `done`.

Top module: `sfdp_table_parser`

## Requirements
- R1: Header word 0 must equal 0x50444653. Any other value ends the parse with error code 1.
- R2: Header word 1 bits 15:0 give the revision, which must be 0x0105 or 0x0106; any other value ends the parse with code 2. `hdr_count` reports bits 19:16 plus one.
- R3: The parameter id is {parameter-header word 0 bits 3:0, word 1 bits 31:24} and must be 0x0FF; otherwise the parse ends with code 3. `tbl_len` is word 0 bits 31:24 capped at MAX_WORDS. `tbl_ptr` is word 1 bits 23:0. The parse ends after exactly `tbl_len` table words, or right after the second parameter-header word when the length is zero.
- R4: If table word 1 bit 31 is set, the parse ends with code 4. Otherwise `capacity` is bits 30:0 shifted right by 3, saturated at CAP_LIMIT (0x1FFFFFF).
- R5: `page_log2` is table word 10 bits 7:4. If capacity shifted right by that amount is zero, the parse ends with code 5.
- R6: Erase type k (k = 0..3) takes its size exponent and opcode from the low then high byte pair of half k%2 of table word 7 + k/2. An exponent of 0 marks the type unused. `sector_log2` is the largest exponent.
- R7: For each used erase type k, the erase time is (word 9 bits [8+7k:4+7k] + 1) times the unit selected by bits [10+7k:9+7k]: 0 selects 1 ms, 1 selects 16 ms, 2 selects 128 ms and 3 selects 1000 ms. The timeout is that time times 2*(word 9 bits 3:0 + 1). Unused types report zero.
- R8: The mass-erase time is (word 10 bits 28:24 + 1) times the unit selected by bits 30:29, which is 16, 256, 4000 or 64000 ms. Its timeout uses the erase multiplier from word 9. The program time is (word 10 bits 12:8 + 1) times 64 us if bit 13 is set, else times 8 us. Its timeout multiplier is 2*(word 10 bits 3:0 + 1).
- R9: The write-enable opcode is 0x06 when table word 15 bit 0 or bit 1 is set. Otherwise it is 0x50 when bit 2 is set. Otherwise it is 0x00, and the parse ends with code 8 if any of bits 6:3 are set.
- R10: Table word 0 bit 21 must be set, else the parse ends with code 6. The fast-read opcode, mode clocks and dummy cycles are word 2 bits 15:8, 7:5 and 4:0.
- R11: `qe_code` is table word 14 bits 22:20 and must be 0 or 4, else the parse ends with code 7. `xip_ok` is bit 9. `xip_method` is 1 if bit 16 is set, 2 if only bit 17 is set, and 0 otherwise.
- R12: If table word 13 bit 3 is set, the status opcode is 0x70 with `stat_legacy` low. Otherwise, if bit 2 is set, it is 0x05 with `stat_legacy` high. Otherwise both are zero.
- R13: `done` is high for exactly one cycle per parse. `err_code` holds its value until the next `start`, which clears every output and restarts the parse even mid-stream. Words offered while no parse is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new parse; clears all results |
| word_valid | input | 1 | A stream word is present this cycle |
| word_data | input | 32 | Stream word |
| done | output | 1 | One-cycle parse completion |
| err_code | output | 4 | 0 good, 1..8 failure reason |
| hdr_count | output | 5 | Number of parameter headers |
| param_rev | output | 16 | Header revision |
| tbl_ptr | output | 24 | Table byte pointer |
| tbl_len | output | 5 | Table words to consume |
| capacity | output | 32 | Capacity in bytes |
| page_log2 | output | 4 | log2 of page size |
| erase_log2 | output | 4x8 | Erase size exponent per type |
| erase_op | output | 4x8 | Erase opcode per type |
| sector_log2 | output | 8 | Largest erase exponent |
| erase_ms | output | 4x32 | Erase time per type, ms |
| erase_to_ms | output | 4x32 | Erase timeout per type, ms |
| mass_ms | output | 32 | Mass-erase time, ms |
| mass_to_ms | output | 32 | Mass-erase timeout, ms |
| prog_us | output | 32 | Page-program time, us |
| prog_to_us | output | 32 | Page-program timeout, us |
| wren_op | output | 8 | Write-enable opcode |
| fr_op | output | 8 | Quad fast-read opcode |
| fr_mode | output | 3 | Fast-read mode clocks |
| fr_dummy | output | 5 | Fast-read dummy cycles |
| qe_code | output | 3 | Quad-enable method code |
| xip_ok | output | 1 | Execute-in-place supported |
| xip_method | output | 2 | Execute-in-place entry method |
| stat_op | output | 8 | Status read opcode |
| stat_legacy | output | 1 | Legacy busy-bit polling |

## Verification
The bench builds the block with its defaults: MAX_WORDS of 20 and CAP_LIMIT of 0x1FFFFFF. With MAX_WORDS at 20, a declared length of 48 exercises the length cap; the bench confirms that `done` is still absent after word 16 and arrives after word 20. With the default CAP_LIMIT, a fully set density field drives the capacity saturation, and a small capacity paired with a 256-byte page reaches the zero-page-count rejection.

// File: rtl/sfdp_parse_pkg.sv
package sfdp_parse_pkg;

    localparam logic [31:0] SIG_WORD = 32'h5044_4653;

    typedef enum logic [3:0] {
        ERR_NONE    = 4'd0,
        ERR_SIG     = 4'd1,
        ERR_REV     = 4'd2,
        ERR_PID     = 4'd3,
        ERR_DENSITY = 4'd4,
        ERR_PAGE    = 4'd5,
        ERR_FASTRD  = 4'd6,
        ERR_QUAD    = 4'd7,
        ERR_WREN    = 4'd8
    } err_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_HDR0, PH_HDR1, PH_PAR0, PH_PAR1, PH_TABLE
    } phase_e;

    function automatic logic [31:0] erase_unit_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'd1;
            2'd1:    return 32'd16;
            2'd2:    return 32'd128;
            default: return 32'd1000;
        endcase
    endfunction

    function automatic logic [31:0] mass_unit_ms(input logic [1:0] sel);
        case (sel)
            2'd0:    return 32'd16;
            2'd1:    return 32'd256;
            2'd2:    return 32'd4000;
            default: return 32'd64000;
        endcase
    endfunction

    function automatic logic [5:0] timeout_mult(input logic [3:0] nib);
        return {1'b0, nib, 1'b0} + 6'd2;
    endfunction

endpackage

// File: rtl/sfdp_erase_time.sv
module sfdp_erase_time
    import sfdp_parse_pkg::*;
(
    input  logic [6:0]  code,
    input  logic [3:0]  mult_nib,
    output logic [31:0] delay_ms,
    output logic [31:0] timeout_ms
);
    always_comb begin
        delay_ms   = (32'(code[4:0]) + 32'd1) * erase_unit_ms(code[6:5]);
        timeout_ms = delay_ms * 32'(timeout_mult(mult_nib));
    end
endmodule

// File: rtl/sfdp_hdr_seq.sv
module sfdp_hdr_seq
    import sfdp_parse_pkg::*;
#(
    parameter int MAX_WORDS = 20,
    localparam int LW = $clog2(MAX_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          word_valid,
    input  logic [31:0]   word_data,
    input  err_e          tbl_err,
    output logic          tbl_we,
    output logic [LW-1:0] tbl_idx,
    output logic          done,
    output err_e          err_code,
    output logic [4:0]    hdr_count,
    output logic [15:0]   param_rev,
    output logic [23:0]   tbl_ptr,
    output logic [LW-1:0] tbl_len
);
    phase_e     phase;
    logic [3:0] id_lo;
    logic       acc;
    logic [LW-1:0] len_in;

    assign acc    = word_valid && !start && (phase != PH_IDLE);
    assign tbl_we = acc && (phase == PH_TABLE);
    assign len_in = (32'(word_data[31:24]) > 32'(MAX_WORDS)) ? LW'(MAX_WORDS)
                                                             : LW'(word_data[31:24]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE; done <= 1'b0; err_code <= ERR_NONE;
            tbl_idx <= '0; tbl_len <= '0; tbl_ptr <= '0;
            hdr_count <= '0; param_rev <= '0; id_lo <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase <= PH_HDR0; err_code <= ERR_NONE;
                tbl_idx <= '0; tbl_len <= '0; tbl_ptr <= '0;
                hdr_count <= '0; param_rev <= '0; id_lo <= '0;
            end else if (acc) begin
                case (phase)
                    PH_HDR0: begin
                        if (word_data != SIG_WORD) begin
                            phase <= PH_IDLE; done <= 1'b1; err_code <= ERR_SIG;
                        end else phase <= PH_HDR1;
                    end
                    PH_HDR1: begin
                        hdr_count <= {1'b0, word_data[19:16]} + 5'd1;
                        param_rev <= word_data[15:0];
                        if (word_data[15:0] != 16'h0105 && word_data[15:0] != 16'h0106) begin
                            phase <= PH_IDLE; done <= 1'b1; err_code <= ERR_REV;
                        end else phase <= PH_PAR0;
                    end
                    PH_PAR0: begin
                        id_lo   <= word_data[3:0];
                        tbl_len <= len_in;
                        phase   <= PH_PAR1;
                    end
                    PH_PAR1: begin
                        tbl_ptr <= word_data[23:0];
                        if ({id_lo, word_data[31:24]} != 12'h0FF) begin
                            phase <= PH_IDLE; done <= 1'b1; err_code <= ERR_PID;
                        end else if (tbl_len == '0) begin
                            phase <= PH_IDLE; done <= 1'b1;
                        end else phase <= PH_TABLE;
                    end
                    PH_TABLE: begin
                        if (tbl_err != ERR_NONE) begin
                            phase <= PH_IDLE; done <= 1'b1; err_code <= tbl_err;
                        end else if (tbl_idx == tbl_len - LW'(1)) begin
                            phase <= PH_IDLE; done <= 1'b1;
                        end else tbl_idx <= tbl_idx + LW'(1);
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_err_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(start)) |-> $stable(err_code));
    assert_idx_in_len_R3: assert property (@(posedge clk) disable iff (rst)
        tbl_we |-> (tbl_idx < tbl_len));
endmodule

// File: rtl/sfdp_table_dec.sv
module sfdp_table_dec
    import sfdp_parse_pkg::*;
#(
    parameter logic [31:0] CAP_LIMIT = 32'h01FF_FFFF,
    parameter int LW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            we,
    input  logic [LW-1:0]   idx,
    input  logic [31:0]     word,
    output err_e            err,
    output logic [31:0]     capacity,
    output logic [3:0]      page_log2,
    output logic [3:0][7:0] erase_log2,
    output logic [3:0][7:0] erase_op,
    output logic [7:0]      sector_log2,
    output logic [3:0][31:0] erase_ms,
    output logic [3:0][31:0] erase_to_ms,
    output logic [31:0]     mass_ms,
    output logic [31:0]     mass_to_ms,
    output logic [31:0]     prog_us,
    output logic [31:0]     prog_to_us,
    output logic [7:0]      wren_op,
    output logic [7:0]      fr_op,
    output logic [2:0]      fr_mode,
    output logic [4:0]      fr_dummy,
    output logic [2:0]      qe_code,
    output logic            xip_ok,
    output logic [1:0]      xip_method,
    output logic [7:0]      stat_op,
    output logic            stat_legacy
);
    localparam int N_ERASE = 4;

    logic [N_ERASE-1:0][31:0] calc_d, calc_t;
    logic [5:0]  erase_mult;
    logic [4:0]  wi;
    logic [31:0] dens, mass_d, prog_d;

    assign wi = 5'(idx);

    for (genvar g = 0; g < N_ERASE; g++) begin : g_erase
        sfdp_erase_time u_time (
            .code       (word[10+7*g -: 7]),
            .mult_nib   (word[3:0]),
            .delay_ms   (calc_d[g]),
            .timeout_ms (calc_t[g])
        );
        assert_unused_erase_R7: assert property (@(posedge clk) disable iff (rst)
            (erase_log2[g] == 8'd0) |-> (erase_ms[g] == 32'd0 && erase_to_ms[g] == 32'd0));
    end

    always_comb begin
        sector_log2 = 8'd0;
        for (int k = 0; k < N_ERASE; k++)
            if (erase_log2[k] > sector_log2) sector_log2 = erase_log2[k];
    end

    always_comb begin
        dens   = 32'(word[30:0]) >> 3;
        mass_d = (32'(word[28:24]) + 32'd1) * mass_unit_ms(word[30:29]);
        prog_d = (32'(word[12:8]) + 32'd1) * (word[13] ? 32'd64 : 32'd8);
    end

    always_comb begin
        err = ERR_NONE;
        if (we) begin
            case (wi)
                5'd0:  if (!word[21]) err = ERR_FASTRD;
                5'd1:  if (word[31]) err = ERR_DENSITY;
                5'd10: if ((capacity >> word[7:4]) == 32'd0) err = ERR_PAGE;
                5'd14: if (word[22:20] != 3'd0 && word[22:20] != 3'd4) err = ERR_QUAD;
                5'd15: if (word[2:0] == 3'd0 && word[6:3] != 4'd0) err = ERR_WREN;
                default: err = ERR_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            capacity <= '0; page_log2 <= '0; erase_log2 <= '0; erase_op <= '0;
            erase_ms <= '0; erase_to_ms <= '0; erase_mult <= '0;
            mass_ms <= '0; mass_to_ms <= '0; prog_us <= '0; prog_to_us <= '0;
            wren_op <= '0; fr_op <= '0; fr_mode <= '0; fr_dummy <= '0;
            qe_code <= '0; xip_ok <= 1'b0; xip_method <= '0;
            stat_op <= '0; stat_legacy <= 1'b0;
        end else if (we) begin
            case (wi)
                5'd1: if (!word[31]) capacity <= (dens >= CAP_LIMIT) ? CAP_LIMIT : dens;
                5'd2: begin
                    fr_op <= word[15:8]; fr_mode <= word[7:5]; fr_dummy <= word[4:0];
                end
                5'd7: begin
                    erase_log2[0] <= word[7:0];   erase_op[0] <= word[15:8];
                    erase_log2[1] <= word[23:16]; erase_op[1] <= word[31:24];
                end
                5'd8: begin
                    erase_log2[2] <= word[7:0];   erase_op[2] <= word[15:8];
                    erase_log2[3] <= word[23:16]; erase_op[3] <= word[31:24];
                end
                5'd9: begin
                    erase_mult <= timeout_mult(word[3:0]);
                    for (int k = 0; k < N_ERASE; k++) begin
                        erase_ms[k]    <= (erase_log2[k] != 8'd0) ? calc_d[k] : 32'd0;
                        erase_to_ms[k] <= (erase_log2[k] != 8'd0) ? calc_t[k] : 32'd0;
                    end
                end
                5'd10: begin
                    page_log2  <= word[7:4];
                    mass_ms    <= mass_d;
                    mass_to_ms <= mass_d * 32'(erase_mult);
                    prog_us    <= prog_d;
                    prog_to_us <= prog_d * 32'(timeout_mult(word[3:0]));
                end
                5'd13: begin
                    if (word[3]) begin
                        stat_op <= 8'h70; stat_legacy <= 1'b0;
                    end else if (word[2]) begin
                        stat_op <= 8'h05; stat_legacy <= 1'b1;
                    end
                end
                5'd14: begin
                    qe_code    <= word[22:20];
                    xip_ok     <= word[9];
                    xip_method <= word[16] ? 2'd1 : (word[17] ? 2'd2 : 2'd0);
                end
                5'd15: begin
                    if (word[0] || word[1])  wren_op <= 8'h06;
                    else if (word[2])        wren_op <= 8'h50;
                end
                default: ;
            endcase
        end
    end

    assert_cap_limit_R4: assert property (@(posedge clk) disable iff (rst)
        capacity <= CAP_LIMIT);
    assert_wren_code_R9: assert property (@(posedge clk) disable iff (rst)
        (wren_op == 8'h00 || wren_op == 8'h06 || wren_op == 8'h50));
    assert_status_pair_R12: assert property (@(posedge clk) disable iff (rst)
        stat_legacy |-> (stat_op == 8'h05));
endmodule

// File: rtl/sfdp_table_parser.sv
module sfdp_table_parser
    import sfdp_parse_pkg::*;
#(
    parameter int MAX_WORDS = 20,
    parameter logic [31:0] CAP_LIMIT = 32'h01FF_FFFF,
    localparam int LW = $clog2(MAX_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             word_valid,
    input  logic [31:0]      word_data,
    output logic             done,
    output logic [3:0]       err_code,
    output logic [4:0]       hdr_count,
    output logic [15:0]      param_rev,
    output logic [23:0]      tbl_ptr,
    output logic [LW-1:0]    tbl_len,
    output logic [31:0]      capacity,
    output logic [3:0]       page_log2,
    output logic [3:0][7:0]  erase_log2,
    output logic [3:0][7:0]  erase_op,
    output logic [7:0]       sector_log2,
    output logic [3:0][31:0] erase_ms,
    output logic [3:0][31:0] erase_to_ms,
    output logic [31:0]      mass_ms,
    output logic [31:0]      mass_to_ms,
    output logic [31:0]      prog_us,
    output logic [31:0]      prog_to_us,
    output logic [7:0]       wren_op,
    output logic [7:0]       fr_op,
    output logic [2:0]       fr_mode,
    output logic [4:0]       fr_dummy,
    output logic [2:0]       qe_code,
    output logic             xip_ok,
    output logic [1:0]       xip_method,
    output logic [7:0]       stat_op,
    output logic             stat_legacy
);
    err_e          tbl_err, err_q;
    logic          tbl_we;
    logic [LW-1:0] tbl_idx;

    sfdp_hdr_seq #(.MAX_WORDS(MAX_WORDS)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .word_valid(word_valid), .word_data(word_data),
        .tbl_err(tbl_err), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .done(done), .err_code(err_q),
        .hdr_count(hdr_count), .param_rev(param_rev),
        .tbl_ptr(tbl_ptr), .tbl_len(tbl_len)
    );

    sfdp_table_dec #(.CAP_LIMIT(CAP_LIMIT), .LW(LW)) u_dec (
        .clk(clk), .rst(rst), .clr(start), .we(tbl_we), .idx(tbl_idx),
        .word(word_data), .err(tbl_err),
        .capacity(capacity), .page_log2(page_log2),
        .erase_log2(erase_log2), .erase_op(erase_op), .sector_log2(sector_log2),
        .erase_ms(erase_ms), .erase_to_ms(erase_to_ms),
        .mass_ms(mass_ms), .mass_to_ms(mass_to_ms),
        .prog_us(prog_us), .prog_to_us(prog_to_us),
        .wren_op(wren_op), .fr_op(fr_op), .fr_mode(fr_mode), .fr_dummy(fr_dummy),
        .qe_code(qe_code), .xip_ok(xip_ok), .xip_method(xip_method),
        .stat_op(stat_op), .stat_legacy(stat_legacy)
    );

    assign err_code = err_q;
endmodule

// File: tb/test_sfdp_table_parser.sv
module test_sfdp_table_parser;
    logic clk = 1'b0, rst = 1'b1, start = 1'b0, word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic done;
    logic [3:0] err_code;
    logic [4:0] hdr_count, tbl_len, fr_dummy;
    logic [15:0] param_rev;
    logic [23:0] tbl_ptr;
    logic [31:0] capacity, mass_ms, mass_to_ms, prog_us, prog_to_us;
    logic [3:0] page_log2;
    logic [3:0][7:0] erase_log2, erase_op;
    logic [7:0] sector_log2, wren_op, fr_op, stat_op;
    logic [3:0][31:0] erase_ms, erase_to_ms;
    logic [2:0] fr_mode, qe_code;
    logic xip_ok, stat_legacy;
    logic [1:0] xip_method;

    int n_chk = 0, n_fail = 0, done_cnt = 0, base = 0;
    logic [31:0] hdr [4];
    logic [31:0] tbl [20];

    always #2.5 clk = ~clk;
    always @(posedge clk) if (done) done_cnt++;

    sfdp_table_parser i_sfdp_table_parser (
        .clk(clk), .rst(rst), .start(start), .word_valid(word_valid), .word_data(word_data),
        .done(done), .err_code(err_code), .hdr_count(hdr_count), .param_rev(param_rev),
        .tbl_ptr(tbl_ptr), .tbl_len(tbl_len), .capacity(capacity), .page_log2(page_log2),
        .erase_log2(erase_log2), .erase_op(erase_op), .sector_log2(sector_log2),
        .erase_ms(erase_ms), .erase_to_ms(erase_to_ms), .mass_ms(mass_ms),
        .mass_to_ms(mass_to_ms), .prog_us(prog_us), .prog_to_us(prog_to_us),
        .wren_op(wren_op), .fr_op(fr_op), .fr_mode(fr_mode), .fr_dummy(fr_dummy),
        .qe_code(qe_code), .xip_ok(xip_ok), .xip_method(xip_method),
        .stat_op(stat_op), .stat_legacy(stat_legacy)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic set_good();
        hdr[0] = 32'h5044_4653; hdr[1] = 32'h0001_0106;
        hdr[2] = 32'h1000_0600; hdr[3] = 32'hFF00_0080;
        for (int i = 0; i < 20; i++) tbl[i] = 32'h0;
        tbl[0]  = 32'h0020_0000; tbl[1]  = 32'h0800_0000; tbl[2]  = 32'h0000_EB44;
        tbl[7]  = 32'h520F_200C; tbl[8]  = 32'h0000_D810; tbl[9]  = 32'h03A6_1241;
        tbl[10] = 32'h2300_2B82; tbl[13] = 32'h0000_0008; tbl[14] = 32'h0001_0200;
        tbl[15] = 32'h0000_0001;
    endtask

    task automatic set_alt();
        set_good();
        hdr[1] = 32'h0000_0105; hdr[2] = 32'h3000_0000;
        tbl[1]  = 32'h7FFF_FFFF; tbl[2] = 32'h0000_EB06;
        tbl[7]  = 32'h0000_200C; tbl[8] = 32'h0; tbl[9] = 32'h0;
        tbl[10] = 32'h6000_0080; tbl[13] = 32'h4; tbl[14] = 32'h0042_0200;
        tbl[15] = 32'h4;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1; word_valid = 1'b0;
        @(negedge clk); start = 1'b0;
        base = done_cnt;
    endtask

    task automatic send(input logic [31:0] w);
        word_valid = 1'b1; word_data = w;
        @(negedge clk); word_valid = 1'b0;
    endtask

    task automatic run(input int ntbl);
        pulse_start();
        for (int i = 0; i < 4; i++) send(hdr[i]);
        for (int i = 0; i < ntbl; i++) send(tbl[i]);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 reset done", 32'(done), 0);
        chk("R13 reset err", 32'(err_code), 0);
        chk("R4 reset capacity", capacity, 0);
    endtask

    task automatic t_good();
        set_good(); run(16);
        chk("R13 good one done", 32'(done_cnt - base), 1);
        chk("R13 good err", 32'(err_code), 0);
        chk("R2 count", 32'(hdr_count), 2);
        chk("R2 rev", 32'(param_rev), 32'h0106);
        chk("R3 ptr", 32'(tbl_ptr), 32'h80);
        chk("R3 len", 32'(tbl_len), 16);
        chk("R4 capacity", capacity, 32'h0100_0000);
        chk("R5 page", 32'(page_log2), 8);
        chk("R6 log2 t1", 32'(erase_log2[1]), 15);
        chk("R6 op t2", 32'(erase_op[2]), 32'hD8);
        chk("R6 sector", 32'(sector_log2), 16);
        chk("R7 t0 ms", erase_ms[0], 80);
        chk("R7 t0 to", erase_to_ms[0], 320);
        chk("R7 t1 ms", erase_ms[1], 384);
        chk("R7 t2 to", erase_to_ms[2], 40000);
        chk("R7 unused t3", erase_ms[3], 0);
        chk("R8 mass", mass_ms, 1024);
        chk("R8 mass to", mass_to_ms, 4096);
        chk("R8 prog", prog_us, 768);
        chk("R8 prog to", prog_to_us, 4608);
        chk("R9 wren", 32'(wren_op), 32'h06);
        chk("R10 fr", {13'd0, fr_op, fr_mode, fr_dummy}, {13'd0, 8'hEB, 3'd2, 5'd4});
        chk("R11 qe/xip", {qe_code, xip_ok, xip_method}, {3'd0, 1'b1, 2'd1});
        chk("R12 status", {stat_legacy, stat_op}, {1'b0, 8'h70});
    endtask

    task automatic t_alt_cap();
        set_alt(); pulse_start();
        for (int i = 0; i < 4; i++) send(hdr[i]);
        for (int i = 0; i < 16; i++) send(tbl[i]);
        chk("R3 no done at 16", 32'(done_cnt - base), 0);
        for (int i = 16; i < 20; i++) send(tbl[i]);
        repeat (2) @(negedge clk);
        chk("R3 done at 20", 32'(done_cnt - base), 1);
        chk("R3 len cap", 32'(tbl_len), 20);
        chk("R4 clamp", capacity, 32'h01FF_FFFF);
        chk("R7 1ms unit", erase_ms[0], 1);
        chk("R7 min mult", erase_to_ms[0], 2);
        chk("R8 64s unit", mass_ms, 64000);
        chk("R8 prog 8us", {prog_us, prog_to_us} == {32'd8, 32'd16} ? 1 : 0, 1);
        chk("R9 wren 50", 32'(wren_op), 32'h50);
        chk("R11 qe4 m2", {qe_code, xip_method}, {3'd4, 2'd2});
        chk("R12 legacy", {stat_legacy, stat_op}, {1'b1, 8'h05});
        chk("R13 alt err", 32'(err_code), 0);
    endtask

    task automatic t_err(input string what, input int exp);
        run(16);
        chk(what, 32'(err_code), 32'(exp));
        chk({what, " one done"}, 32'(done_cnt - base), 1);
    endtask

    task automatic t_errors();
        set_good(); hdr[0] = 32'h5044_4654; t_err("R1 signature", 1);
        chk("R13 ignored after stop", capacity, 0);
        set_good(); hdr[1] = 32'h0001_0104; t_err("R2 revision", 2);
        set_good(); hdr[2] = 32'h1000_0001; t_err("R3 param id", 3);
        set_good(); tbl[1] = 32'h8000_0000; t_err("R4 density", 4);
        set_good(); tbl[1] = 32'h0000_0080; t_err("R5 page count", 5);
        set_good(); tbl[0] = 32'h0; t_err("R10 fast read", 6);
        set_good(); tbl[14] = 32'h0030_0000; t_err("R11 quad", 7);
        set_good(); tbl[15] = 32'h10; t_err("R9 wren bad", 8);
        chk("R13 err held", 32'(err_code), 8);
        set_good(); tbl[15] = 32'h11; t_err("R9 wren b0 wins", 0);
        chk("R9 wren b0 op", 32'(wren_op), 32'h06);
    endtask

    task automatic t_len0();
        set_good(); hdr[2] = 32'h0000_0000; run(0);
        chk("R3 zero len done", 32'(done_cnt - base), 1);
        chk("R3 zero len err", 32'(err_code), 0);
        chk("R3 zero len cap", capacity, 0);
    endtask

    task automatic t_restart();
        set_good(); hdr[0] = 32'h0; run(0);
        chk("R1 restart pre", 32'(err_code), 1);
        set_good(); pulse_start();
        send(hdr[0]); send(hdr[1]); send(hdr[2]);
        set_alt(); run(20);
        chk("R13 restart err clr", 32'(err_code), 0);
        chk("R13 restart done", 32'(done_cnt - base), 1);
        chk("R13 restart rev", 32'(param_rev), 32'h0105);
    endtask

    initial begin
        #600us;
        $display("FAIL watchdog: actual hung expected finish");
        n_fail++; n_chk++;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_good();
        t_alt_cap();
        t_errors();
        t_len0();
        t_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule